// File: doc/BRIEF.md
# UART interrupt merge and mask controller

This block gathers the four interrupt causes of a serial port channel into one level-sensitive interrupt line. Four single-cycle event inputs (receive, error, transmit, modem) set latched cause bits. A mask register hides causes from the line, and a derived pending view shows the causes that are set and not masked. Software clears causes by writing ones, either through the pending view or directly to the cause register. The mask is loaded by a plain write.

The block also looks at the transmit FIFO. When the FIFO is enabled and its fill count is at or below a trigger level, the transmit cause is raised again on every cycle. The trigger level is a 3-bit field taken from the FIFO control word, scaled by a factor that is fixed by the channel number at elaboration. Moving data and decoding bus addresses are left to neighbouring logic.

Top module: `uart_irq_merge`

## Requirements
- R1: After reset the cause, mask and pending values all read zero and `irq` is low.
- R2: A high pulse on `evt_rx`, `evt_err`, `evt_tx` or `evt_modem` sets cause bit 0, 1, 2 or 3 respectively. That bit reads one from the clock edge that samples the pulse and stays set until it is cleared.
- R3: The pending value (read select 0) equals the cause bits (read select 1) ANDed with the inverse of the mask (read select 2). Masking never alters the cause bits.
- R4: `irq` is high exactly when the pending value is nonzero, so a cause hidden by its mask bit does not drive the line.
- R5: A write with write select 0 clears, at that clock edge, every cause bit whose `reg_wdata` bit is one. The pending view clears with those bits.
- R6: A write with write select 1 clears, at that clock edge, every cause bit whose `reg_wdata` bit is one. The other bits are unchanged.
- R7: A write with write select 2 loads `reg_wdata` into the mask at that clock edge.
- R8: When a cause bit is set and cleared at the same edge, it ends up set.
- R9: The transmit-level check uses these fields. FIFO enable is `fifo_ctrl` bit 0. The trigger field is `fifo_ctrl` bits 10:8. The transmit count is `fifo_stat` bits 23:16. When the FIFO is enabled and the count is at or below the trigger level, cause bit 2 is set at every edge, and this set wins over a clear at the same edge.
- R10: The trigger level is the field value times 32 for CHANNEL 0, times 8 for CHANNEL 1 or 4, and times 2 for CHANNEL 2 or 3. Any other CHANNEL uses a level of 0.
- R11: With `fifo_ctrl` bit 0 low, the transmit-level check sets nothing, whatever the count is.
- R12: Write select 3 changes no state, and read select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_rx | input | 1 | Receive event pulse |
| evt_err | input | 1 | Error event pulse |
| evt_tx | input | 1 | Transmit event pulse |
| evt_modem | input | 1 | Modem event pulse |
| reg_wr | input | 1 | Write strobe |
| reg_wsel | input | 2 | Write target: 0 pending clear, 1 cause clear, 2 mask load, 3 none |
| reg_wdata | input | 4 | Write data |
| reg_rsel | input | 2 | Read target: 0 pending, 1 cause, 2 mask, 3 zero |
| reg_rdata | output | 4 | Read data for `reg_rsel`, combinational |
| fifo_ctrl | input | 32 | FIFO control word (enable and transmit trigger field) |
| fifo_stat | input | 32 | FIFO status word (transmit count) |
| irq | output | 1 | Merged level interrupt |

## Verification
The bench runs four copies of the block, with channels 0, 1, 3 and 6, against a behavioural model. It drives counts at each channel's exact trigger level and one above it. A wrong scale factor or an off-by-one compare therefore shows up as a transmit cause that appears on the wrong channel. It hits set and clear on the same edge, both from event pulses and from the continuously asserted transmit-level condition. A design that gave the clear priority would read zero where a one is expected. It also checks that clearing through the pending view removes the cause bits, that masking leaves those bits intact, and that the unused select changes nothing. A design that only cleared the pending view, or that let the mask overwrite causes, would then show stale or lost bits when the mask is removed.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

   localparam int SRC_W     = 4;
   localparam int SRC_RX    = 0;
   localparam int SRC_ERR   = 1;
   localparam int SRC_TX    = 2;
   localparam int SRC_MODEM = 3;

   typedef enum logic [1:0] {
      SEL_PEND = 2'd0,
      SEL_SRC  = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // Left shift that scales the trigger field; negative means level zero.
   function automatic int chan_shift(input int ch);
      case (ch)
         0:       return 5;
         1, 4:    return 3;
         2, 3:    return 1;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/irq_set_clr_reg.sv
`timescale 1ns/1ps
module irq_set_clr_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("irq_set_clr_reg: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bit_q <= 1'b0;
         else if (set[i]) bit_q <= 1'b1;
         else if (clr[i]) bit_q <= 1'b0;
      end

      assign q[i] = bit_q;

      // R8: a set wins over a clear at the same edge
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> q[i]);

      // R6: a lone clear drops the bit
      a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !q[i]);

      // R2: a latched cause holds without set or clear
      a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!set[i] && !clr[i]) |=> $stable(q[i]));
   end

endmodule

// File: rtl/irq_load_reg.sv
`timescale 1ns/1ps
module irq_load_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   // R7: a load takes the write data
   a_r7_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(d)));

   // R12: without a load the mask keeps its value
   a_r12_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));

endmodule

// File: rtl/irq_tx_threshold.sv
`timescale 1ns/1ps
module irq_tx_threshold
   import uart_irq_pkg::*;
#(
   parameter int CHANNEL  = 0,
   parameter int CTRL_W   = 32,
   parameter int STAT_W   = 32,
   parameter int EN_BIT   = 0,
   parameter int TRIG_LSB = 8,
   parameter int TRIG_W   = 3,
   parameter int CNT_LSB  = 16,
   parameter int CNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] fifo_ctrl,
   input  logic [STAT_W-1:0] fifo_stat,
   output logic              hit
);

   localparam int SHIFT = chan_shift(CHANNEL);
   localparam int LVL_W = TRIG_W + 5;
   localparam int CMP_W = (LVL_W > CNT_W) ? LVL_W : CNT_W;

   generate
      if (TRIG_LSB + TRIG_W > CTRL_W) begin : g_bad_trig
         $error("irq_tx_threshold: trigger field exceeds control word");
      end
      if (EN_BIT >= CTRL_W) begin : g_bad_en
         $error("irq_tx_threshold: enable bit outside control word");
      end
      if (CNT_LSB + CNT_W > STAT_W) begin : g_bad_cnt
         $error("irq_tx_threshold: count field exceeds status word");
      end
   endgenerate

   logic [TRIG_W-1:0] field;
   logic [CNT_W-1:0]  cnt;
   logic              en;
   logic [CMP_W-1:0]  level;
   logic [CMP_W-1:0]  cnt_x;
   logic              unused_word_bits;

   assign field = fifo_ctrl[TRIG_LSB +: TRIG_W];
   assign cnt   = fifo_stat[CNT_LSB +: CNT_W];
   assign en    = fifo_ctrl[EN_BIT];
   assign cnt_x = CMP_W'(cnt);
   assign unused_word_bits = ^{fifo_ctrl, fifo_stat};

   generate
      if (SHIFT < 0) begin : g_zero_level
         assign level = '0;

         // R10: channels without a factor only trigger on an empty FIFO
         a_r10_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_stat[CNT_LSB +: CNT_W] != '0) |-> !hit);
      end else begin : g_scaled_level
         assign level = CMP_W'(field) << SHIFT;
      end
   endgenerate

   assign hit = en && (cnt_x <= level);

   // R11: a disabled FIFO never triggers
   a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_ctrl[EN_BIT] |-> !hit);

   // R9: an empty enabled FIFO is always at or below any level
   a_r9_empty_triggers: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ctrl[EN_BIT] && (fifo_stat[CNT_LSB +: CNT_W] == '0)) |-> hit);

endmodule

// File: rtl/uart_irq_merge.sv
`timescale 1ns/1ps
module uart_irq_merge
   import uart_irq_pkg::*;
#(
   parameter int CHANNEL     = 0,
   parameter int CTRL_W      = 32,
   parameter int STAT_W      = 32,
   parameter int FIFO_EN_BIT = 0,
   parameter int TXTRIG_LSB  = 8,
   parameter int TXTRIG_W    = 3,
   parameter int TXCNT_LSB   = 16,
   parameter int TXCNT_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_rx,
   input  logic              evt_err,
   input  logic              evt_tx,
   input  logic              evt_modem,
   input  logic              reg_wr,
   input  logic [1:0]        reg_wsel,
   input  logic [SRC_W-1:0]  reg_wdata,
   input  logic [1:0]        reg_rsel,
   output logic [SRC_W-1:0]  reg_rdata,
   input  logic [CTRL_W-1:0] fifo_ctrl,
   input  logic [STAT_W-1:0] fifo_stat,
   output logic              irq
);

   generate
      if (CHANNEL < 0) begin : g_bad_chan
         $error("uart_irq_merge: CHANNEL must not be negative");
      end
   endgenerate

   reg_sel_e         wsel;
   reg_sel_e         rsel;
   logic             tx_hit;
   logic [SRC_W-1:0] set_v;
   logic [SRC_W-1:0] clr_v;
   logic             mask_ld;
   logic [SRC_W-1:0] src_q;
   logic [SRC_W-1:0] mask_q;
   logic [SRC_W-1:0] pend;

   assign wsel = reg_sel_e'(reg_wsel);
   assign rsel = reg_sel_e'(reg_rsel);

   irq_tx_threshold #(
      .CHANNEL  (CHANNEL),
      .CTRL_W   (CTRL_W),
      .STAT_W   (STAT_W),
      .EN_BIT   (FIFO_EN_BIT),
      .TRIG_LSB (TXTRIG_LSB),
      .TRIG_W   (TXTRIG_W),
      .CNT_LSB  (TXCNT_LSB),
      .CNT_W    (TXCNT_W)
   ) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_ctrl (fifo_ctrl),
      .fifo_stat (fifo_stat),
      .hit       (tx_hit)
   );

   always_comb begin
      set_v            = '0;
      set_v[SRC_RX]    = evt_rx;
      set_v[SRC_ERR]   = evt_err;
      set_v[SRC_TX]    = evt_tx | tx_hit;
      set_v[SRC_MODEM] = evt_modem;
   end

   always_comb begin
      clr_v = '0;
      if (reg_wr && ((wsel == SEL_PEND) || (wsel == SEL_SRC))) clr_v = reg_wdata;
   end

   assign mask_ld = reg_wr && (wsel == SEL_MASK);

   irq_set_clr_reg #(.W(SRC_W)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v),
      .clr   (clr_v),
      .q     (src_q)
   );

   irq_load_reg #(.W(SRC_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (mask_ld),
      .d     (reg_wdata),
      .q     (mask_q)
   );

   assign pend = src_q & ~mask_q;
   assign irq  = |pend;

   always_comb begin
      case (rsel)
         SEL_PEND: reg_rdata = pend;
         SEL_SRC:  reg_rdata = src_q;
         SEL_MASK: reg_rdata = mask_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R4: a fully masked block keeps the line low
   a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);

   // R5: a pending-view write removes the written cause bits
   a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (wsel == SEL_PEND) && ((set_v & reg_wdata) == '0))
         |=> ((src_q & $past(reg_wdata)) == '0));

   // R12: the unused write select leaves all state alone
   a_r12_none_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (wsel == SEL_NONE) && (set_v == '0))
         |=> ($stable(src_q) && $stable(mask_q)));

   // R3: any raised line comes from a set cause bit
   a_r3_line_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (src_q != '0));

endmodule

// File: tb/uart_irq_merge_tb.sv
`timescale 1ns/1ps
module uart_irq_merge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ev = 4'h0;
   logic        wr = 1'b0;
   logic [1:0]  wsel = 2'd3;
   logic [3:0]  wd = 4'h0;
   logic [1:0]  rsel = 2'd0;
   logic [31:0] fctl = 32'h0;
   logic [31:0] fst = 32'h0;
   logic [3:0]  rd_o [4];
   logic        irq_o [4];

   int checks = 0, errors = 0;
   int mchecks = 0, merrs = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   int chans [4] = '{0, 1, 3, 6};
   logic [3:0] m_src [4] = '{4'h0, 4'h0, 4'h0, 4'h0};
   logic [3:0] m_mask [4] = '{4'h0, 4'h0, 4'h0, 4'h0};
   logic [3:0] m_set, m_clr, m_exp;

   always #2.5 clk = ~clk;

   uart_irq_merge #(.CHANNEL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_rx(ev[0]), .evt_err(ev[1]), .evt_tx(ev[2]),
      .evt_modem(ev[3]), .reg_wr(wr), .reg_wsel(wsel), .reg_wdata(wd),
      .reg_rsel(rsel), .reg_rdata(rd_o[0]), .fifo_ctrl(fctl), .fifo_stat(fst),
      .irq(irq_o[0]));
   uart_irq_merge #(.CHANNEL(1)) u_dut_c1 (
      .clk(clk), .rst_n(rst_n), .evt_rx(ev[0]), .evt_err(ev[1]), .evt_tx(ev[2]),
      .evt_modem(ev[3]), .reg_wr(wr), .reg_wsel(wsel), .reg_wdata(wd),
      .reg_rsel(rsel), .reg_rdata(rd_o[1]), .fifo_ctrl(fctl), .fifo_stat(fst),
      .irq(irq_o[1]));
   uart_irq_merge #(.CHANNEL(3)) u_dut_c3 (
      .clk(clk), .rst_n(rst_n), .evt_rx(ev[0]), .evt_err(ev[1]), .evt_tx(ev[2]),
      .evt_modem(ev[3]), .reg_wr(wr), .reg_wsel(wsel), .reg_wdata(wd),
      .reg_rsel(rsel), .reg_rdata(rd_o[2]), .fifo_ctrl(fctl), .fifo_stat(fst),
      .irq(irq_o[2]));
   uart_irq_merge #(.CHANNEL(6)) u_dut_c6 (
      .clk(clk), .rst_n(rst_n), .evt_rx(ev[0]), .evt_err(ev[1]), .evt_tx(ev[2]),
      .evt_modem(ev[3]), .reg_wr(wr), .reg_wsel(wsel), .reg_wdata(wd),
      .reg_rsel(rsel), .reg_rdata(rd_o[3]), .fifo_ctrl(fctl), .fifo_stat(fst),
      .irq(irq_o[3]));

   // R10: trigger level per channel
   function automatic int lvl(input int ch, input int f);
      case (ch)
         0:       return f * 32;
         1, 4:    return f * 8;
         2, 3:    return f * 2;
         default: return 0;
      endcase
   endfunction

   // Behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      for (int k = 0; k < 4; k++) begin
         if (!rst_n) begin
            m_src[k]  = 4'h0;
            m_mask[k] = 4'h0;
         end else begin
            m_set = ev;
            if (fctl[0] && (int'(fst[23:16]) <= lvl(chans[k], int'(fctl[10:8]))))
               m_set[2] = 1'b1;
            m_clr = (wr && (wsel == 2'd0 || wsel == 2'd1)) ? wd : 4'h0;
            m_src[k] = (m_src[k] & ~m_clr) | m_set;
            if (wr && wsel == 2'd2) m_mask[k] = wd;
         end
      end
   end

   // Per-cycle comparison, sampled just after the falling edge
   always @(negedge clk) begin
      #1;
      if (chk_on) begin
         for (int k = 0; k < 4; k++) begin
            case (rsel)
               2'd0:    m_exp = m_src[k] & ~m_mask[k];
               2'd1:    m_exp = m_src[k];
               2'd2:    m_exp = m_mask[k];
               default: m_exp = 4'h0;
            endcase
            mchecks++;
            if (rd_o[k] !== m_exp) begin
               merrs++;
               $display("FAIL R3 model read ch%0d sel %0d: actual %h expected %h",
                        chans[k], rsel, rd_o[k], m_exp);
            end
            mchecks++;
            if (irq_o[k] !== (|(m_src[k] & ~m_mask[k]))) begin
               merrs++;
               $display("FAIL R4 model irq ch%0d: actual %b expected %b",
                        chans[k], irq_o[k], |(m_src[k] & ~m_mask[k]));
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] e, input logic w, input logic [1:0] s,
                       input logic [3:0] d);
      @(negedge clk);
      ev = e; wr = w; wsel = s; wd = d;
   endtask

   task automatic look(input logic [1:0] s);
      @(negedge clk);
      ev = 4'h0; wr = 1'b0; wsel = 2'd3; wd = 4'h0; rsel = s;
      #1;
   endtask

   // New FIFO words, with a cause clear on the same edge
   task automatic fifo_case(input string tag, input logic [31:0] c, input logic [7:0] n,
                            input logic [3:0] e0, input logic [3:0] e1,
                            input logic [3:0] e3, input logic [3:0] e6);
      @(negedge clk);
      ev = 4'h0; wr = 1'b1; wsel = 2'd1; wd = 4'hF;
      fctl = c; fst = {8'h00, n, 16'h0000};
      look(2'd1);
      chk({tag, " ch0"}, rd_o[0], e0);
      chk({tag, " ch1"}, rd_o[1], e1);
      chk({tag, " ch3"}, rd_o[2], e3);
      chk({tag, " ch6"}, rd_o[3], e6);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;

      look(2'd0); chk("R1 pending after reset", rd_o[0], 4'h0);
      chk("R1 irq after reset", {3'b0, irq_o[0]}, 4'h0);
      look(2'd1); chk("R1 cause after reset", rd_o[0], 4'h0);
      look(2'd2); chk("R1 mask after reset", rd_o[0], 4'h0);

      step(4'b0001, 1'b0, 2'd3, 4'h0);
      look(2'd1); chk("R2 rx sets bit0", rd_o[0], 4'b0001);
      look(2'd0); chk("R3 pending follows cause", rd_o[0], 4'b0001);
      chk("R4 irq raised", {3'b0, irq_o[0]}, 4'h1);
      step(4'b0010, 1'b0, 2'd3, 4'h0);
      look(2'd1); chk("R2 err sets bit1", rd_o[0], 4'b0011);
      step(4'b0100, 1'b0, 2'd3, 4'h0);
      look(2'd1); chk("R2 tx sets bit2", rd_o[0], 4'b0111);
      step(4'b1000, 1'b0, 2'd3, 4'h0);
      look(2'd1); chk("R2 modem sets bit3", rd_o[0], 4'b1111);

      step(4'h0, 1'b1, 2'd2, 4'b0101);
      look(2'd2); chk("R7 mask loaded", rd_o[0], 4'b0101);
      look(2'd0); chk("R3 masked pending", rd_o[0], 4'b1010);
      step(4'h0, 1'b1, 2'd2, 4'b1111);
      look(2'd0); chk("R3 all masked pending", rd_o[0], 4'h0);
      chk("R4 irq low when masked", {3'b0, irq_o[0]}, 4'h0);
      look(2'd1); chk("R3 mask keeps causes", rd_o[0], 4'b1111);

      step(4'h0, 1'b1, 2'd2, 4'b0000);
      step(4'h0, 1'b1, 2'd0, 4'b0011);
      look(2'd1); chk("R5 pending write clears cause", rd_o[0], 4'b1100);
      look(2'd0); chk("R5 pending view cleared", rd_o[0], 4'b1100);
      step(4'h0, 1'b1, 2'd1, 4'b0100);
      look(2'd1); chk("R6 cause write clears bit", rd_o[0], 4'b1000);
      step(4'h0, 1'b1, 2'd1, 4'b1000);
      look(2'd1); chk("R6 cause empty", rd_o[0], 4'h0);
      chk("R4 irq low when empty", {3'b0, irq_o[0]}, 4'h0);

      step(4'b0010, 1'b1, 2'd1, 4'b0010);
      look(2'd1); chk("R8 event beats cause clear", rd_o[0], 4'b0010);
      step(4'b1000, 1'b1, 2'd0, 4'b1111);
      look(2'd1); chk("R8 event beats pending clear", rd_o[0], 4'b1000);

      step(4'h0, 1'b1, 2'd3, 4'b1111);
      look(2'd1); chk("R12 none write keeps cause", rd_o[0], 4'b1000);
      look(2'd2); chk("R12 none write keeps mask", rd_o[0], 4'h0);
      look(2'd3); chk("R12 none read is zero", rd_o[0], 4'h0);

      fifo_case("R10 field1 cnt2",   32'h0000_0101, 8'd2,   4'h4, 4'h4, 4'h4, 4'h0);
      fifo_case("R10 field1 cnt3",   32'h0000_0101, 8'd3,   4'h4, 4'h4, 4'h0, 4'h0);
      fifo_case("R10 field1 cnt8",   32'h0000_0101, 8'd8,   4'h4, 4'h4, 4'h0, 4'h0);
      fifo_case("R10 field1 cnt9",   32'h0000_0101, 8'd9,   4'h4, 4'h0, 4'h0, 4'h0);
      fifo_case("R10 field1 cnt32",  32'h0000_0101, 8'd32,  4'h4, 4'h0, 4'h0, 4'h0);
      fifo_case("R10 field1 cnt33",  32'h0000_0101, 8'd33,  4'h0, 4'h0, 4'h0, 4'h0);
      fifo_case("R10 field7 cnt224", 32'h0000_0701, 8'd224, 4'h4, 4'h0, 4'h0, 4'h0);
      fifo_case("R10 field7 cnt225", 32'h0000_0701, 8'd225, 4'h0, 4'h0, 4'h0, 4'h0);
      fifo_case("R9 field0 cnt0",    32'h0000_0001, 8'd0,   4'h4, 4'h4, 4'h4, 4'h4);

      step(4'h0, 1'b1, 2'd1, 4'b0100);
      look(2'd1); chk("R9 level beats clear ch0", rd_o[0], 4'h4);
      chk("R9 level beats clear ch6", rd_o[3], 4'h4);
      chk("R9 irq from level", {3'b0, irq_o[0]}, 4'h1);

      fifo_case("R11 disabled cnt0", 32'h0000_0700, 8'd0, 4'h0, 4'h0, 4'h0, 4'h0);
      look(2'd0); chk("R11 disabled irq low", {3'b0, irq_o[3]}, 4'h0);

      look(2'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errors + merrs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors",
                  checks + mchecks + 1, errors + merrs + 1);
         $finish;
      end
   end

endmodule